// File: doc/BRIEF.md
# Two-Dimensional Display Fetch Address Sequencer

This block produces the source read addresses for a display fetch channel. Software describes a block as a number of frames, each made of a number of elements. It gives a start address, an element size and two signed index offsets. Once enabled, the sequencer offers one address per cycle on a valid/ready port. It moves to the next address each time the consumer accepts one, and it raises a status bit when the last address of the block is taken.

Software writes a shadow copy of the walk geometry. A separate load request copies the shadow into the working copy. When the channel is idle, the copy is made at once. When a block is in flight, the copy waits for that block's last address, so a frame never mixes two settings. A repeat setting restarts the walk from the start address as soon as a block ends. Without it, the channel clears its own enable after a single block.

Top module: `dma2d_addr_seq`

## Requirements
- R1: After reset, `addr_valid` and `irq` are 0. All registers are 0 and no load request is pending.
- R2: When the format mode field (FMT bits 1:0) is not 3, each accepted address is followed by the previous address plus the element size. The element size is 1, 2, 4 or 8 bytes for FMT bits 3:2 equal to 0, 1, 2 or 3.
- R3: When the mode field is 3, an accepted address that is not the last of its frame is followed by address + size + EIDX − 1. EIDX is a signed 16-bit value written at select 5.
- R4: When the mode field is 3, the last address of a frame that is not the last frame is followed by address + size + FIDX − 1. FIDX is a signed 16-bit value written at select 6.
- R5: A block holds ECNT × FCNT addresses, with ECNT at select 3 and FCNT at select 4. A count of 0 acts as 1.
- R6: CTRL is at select 0, with bit 0 enable, bit 1 interrupt enable, bit 2 repeat and bit 3 load request. With repeat set, the address after a block's last one is the start address. With repeat clear, the enable bit clears at block end and no address is offered until software sets it again.
- R7: Writes to FMT (select 1), START (select 2), counts and indices change only the shadow set. A CTRL write with bit 3 set loads the shadow into the working set. The load happens at once if the channel is idle, or at the end of the current block if it is running.
- R8: The status bit (select 7, bit 0) is set at each block end and is cleared by writing 1 to it. Writing 0 to it has no effect, and a block end while it is set leaves it set. `irq` equals status AND the interrupt enable bit.
- R9: Clearing enable drops `addr_valid` on the next cycle and abandons the block. Setting it again restarts from the start address.
- R10: While `addr_valid` is high and `addr_ready` is low, the address is held and stays valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | AW | Register write data |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr_out | output | AW | Offered read address |
| irq | output | 1 | Block-end interrupt |

## Verification
The hardest case to reach is a load request that arrives while a block is part way through. The shadow must not leak into the running block, yet it must take effect exactly at the block boundary. The stimulus sets up a repeating block and lets it run a few addresses. It then rewrites the start address and issues the load request mid-frame. A reference model then follows every address across the boundary. An uneven ready pattern during the double-indexed walk covers stalls on both element and frame steps.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_FMT   = 3'd1;
    localparam logic [2:0] SEL_START = 3'd2;
    localparam logic [2:0] SEL_ECNT  = 3'd3;
    localparam logic [2:0] SEL_FCNT  = 3'd4;
    localparam logic [2:0] SEL_EIDX  = 3'd5;
    localparam logic [2:0] SEL_FIDX  = 3'd6;
    localparam logic [2:0] SEL_STAT  = 3'd7;

    localparam int CTL_EN    = 0;
    localparam int CTL_IRQEN = 1;
    localparam int CTL_RPT   = 2;
    localparam int CTL_LOAD  = 3;

    typedef enum logic [1:0] {
        WALK_INC0 = 2'd0,
        WALK_INC1 = 2'd1,
        WALK_INC2 = 2'd2,
        WALK_DBL  = 2'd3
    } walk_mode_e;
endpackage

// File: rtl/sq_regfile.sv
module sq_regfile #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [AW-1:0]        wr_data,
    input  logic                 busy,
    input  logic                 blk_end,
    output logic                 en,
    output logic                 irq_en,
    output logic                 rpt,
    output logic                 pend,
    output logic                 status,
    output sq_pkg::walk_mode_e   act_mode,
    output logic [1:0]           act_esz,
    output logic [AW-1:0]        act_start,
    output logic [CW-1:0]        act_ecnt,
    output logic [CW-1:0]        act_fcnt,
    output logic [IW-1:0]        act_eidx,
    output logic [IW-1:0]        act_fidx,
    output logic [AW-1:0]        restart_addr
);
    import sq_pkg::*;

    typedef struct packed {
        walk_mode_e    mode;
        logic [1:0]    esz;
        logic [AW-1:0] start;
        logic [CW-1:0] ecnt;
        logic [CW-1:0] fcnt;
        logic [IW-1:0] eidx;
        logic [IW-1:0] fidx;
    } geom_t;

    typedef struct packed {
        geom_t shd;
        geom_t act;
        logic  en;
        logic  irq_en;
        logic  rpt;
        logic  pend;
        logic  status;
    } rf_t;

    rf_t  st_d, st_q;
    logic load_now;

    always_comb begin
        st_d     = st_q;
        load_now = st_q.pend && (!busy || blk_end);
        if (load_now) begin
            st_d.act  = st_q.shd;
            st_d.pend = 1'b0;
        end
        if (blk_end) begin
            st_d.status = 1'b1;
            if (!st_q.rpt) st_d.en = 1'b0;
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    st_d.en     = wr_data[CTL_EN];
                    st_d.irq_en = wr_data[CTL_IRQEN];
                    st_d.rpt    = wr_data[CTL_RPT];
                    if (wr_data[CTL_LOAD]) st_d.pend = 1'b1;
                end
                SEL_FMT: begin
                    st_d.shd.mode = walk_mode_e'(wr_data[1:0]);
                    st_d.shd.esz  = wr_data[3:2];
                end
                SEL_START: st_d.shd.start = wr_data;
                SEL_ECNT:  st_d.shd.ecnt  = wr_data[CW-1:0];
                SEL_FCNT:  st_d.shd.fcnt  = wr_data[CW-1:0];
                SEL_EIDX:  st_d.shd.eidx  = wr_data[IW-1:0];
                SEL_FIDX:  st_d.shd.fidx  = wr_data[IW-1:0];
                default: begin
                    if (wr_data[0] && !blk_end) st_d.status = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign en           = st_q.en;
    assign irq_en       = st_q.irq_en;
    assign rpt          = st_q.rpt;
    assign pend         = st_q.pend;
    assign status       = st_q.status;
    assign act_mode     = st_q.act.mode;
    assign act_esz      = st_q.act.esz;
    assign act_start    = st_q.act.start;
    assign act_ecnt     = st_q.act.ecnt;
    assign act_fcnt     = st_q.act.fcnt;
    assign act_eidx     = st_q.act.eidx;
    assign act_fidx     = st_q.act.fidx;
    assign restart_addr = load_now ? st_q.shd.start : st_q.act.start;
endmodule

// File: rtl/sq_walker.sv
module sq_walker #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               rpt,
    input  logic               ready,
    input  sq_pkg::walk_mode_e mode,
    input  logic [1:0]         esz,
    input  logic [CW-1:0]      ecnt,
    input  logic [CW-1:0]      fcnt,
    input  logic [IW-1:0]      eidx,
    input  logic [IW-1:0]      fidx,
    input  logic [AW-1:0]      restart_addr,
    output logic               valid,
    output logic [AW-1:0]      addr,
    output logic               busy,
    output logic               blk_end
);
    import sq_pkg::*;

    localparam int XW = AW - IW;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] cur;
        logic [CW-1:0] e;
        logic [CW-1:0] f;
    } walk_t;

    walk_t         st_d, st_q;
    logic [AW-1:0] bytes, step_e, step_f;
    logic          last_e, last_f, accept;

    always_comb begin
        bytes  = AW'(1) << esz;
        step_e = bytes;
        step_f = bytes;
        if (mode == WALK_DBL) begin
            step_e = bytes + {{XW{eidx[IW-1]}}, eidx} - AW'(1);
            step_f = bytes + {{XW{fidx[IW-1]}}, fidx} - AW'(1);
        end
        last_e  = ({1'b0, st_q.e} + 1'b1) >= {1'b0, ecnt};
        last_f  = ({1'b0, st_q.f} + 1'b1) >= {1'b0, fcnt};
        accept  = st_q.busy && en && ready;
        blk_end = accept && last_e && last_f;

        st_d = st_q;
        if (st_q.busy && !en) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy) begin
            if (en) begin
                st_d.busy = 1'b1;
                st_d.cur  = restart_addr;
                st_d.e    = '0;
                st_d.f    = '0;
            end
        end else if (accept) begin
            if (!last_e) begin
                st_d.cur = st_q.cur + step_e;
                st_d.e   = st_q.e + 1'b1;
            end else if (!last_f) begin
                st_d.cur = st_q.cur + step_f;
                st_d.e   = '0;
                st_d.f   = st_q.f + 1'b1;
            end else if (rpt) begin
                st_d.cur = restart_addr;
                st_d.e   = '0;
                st_d.f   = '0;
            end else begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid = st_q.busy && en;
    assign addr  = st_q.cur;
    assign busy  = st_q.busy;
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          addr_ready,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out,
    output logic          irq
);
    import sq_pkg::*;

    logic          en, irq_en, rpt, pend, status, busy, blk_end;
    walk_mode_e    act_mode;
    logic [1:0]    act_esz;
    logic [AW-1:0] act_start, restart_addr;
    logic [CW-1:0] act_ecnt, act_fcnt;
    logic [IW-1:0] act_eidx, act_fidx;

    sq_regfile #(.AW(AW), .CW(CW), .IW(IW)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .blk_end(blk_end), .en(en), .irq_en(irq_en), .rpt(rpt),
        .pend(pend), .status(status), .act_mode(act_mode), .act_esz(act_esz),
        .act_start(act_start), .act_ecnt(act_ecnt), .act_fcnt(act_fcnt),
        .act_eidx(act_eidx), .act_fidx(act_fidx), .restart_addr(restart_addr)
    );

    sq_walker #(.AW(AW), .CW(CW), .IW(IW)) i_walk (
        .clk(clk), .rst(rst), .en(en), .rpt(rpt), .ready(addr_ready),
        .mode(act_mode), .esz(act_esz), .ecnt(act_ecnt), .fcnt(act_fcnt),
        .eidx(act_eidx), .fidx(act_fidx), .restart_addr(restart_addr),
        .valid(addr_valid), .addr(addr_out), .busy(busy), .blk_end(blk_end)
    );

    assign irq = status && irq_en;
endmodule

// File: rtl/dma2d_addr_seq_chk.sv
module dma2d_addr_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [2:0]    wr_sel,
    input logic [AW-1:0] wr_data,
    input logic          addr_ready,
    input logic          addr_valid,
    input logic [AW-1:0] addr_out,
    input logic          busy,
    input logic          blk_end,
    input logic          rpt,
    input logic          status,
    input logic [AW-1:0] act_start
);
    logic ctrl_wr, stat_clr;
    assign ctrl_wr  = wr_en && (wr_sel == 3'd0);
    assign stat_clr = wr_en && (wr_sel == 3'd7) && wr_data[0];

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !addr_valid);

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready && !ctrl_wr) |=> (addr_valid && $stable(addr_out)));

    p_single_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (blk_end && !rpt && !ctrl_wr) |=> !addr_valid);

    p_repeat_go_r6: assert property (@(posedge clk) disable iff (rst)
        (blk_end && rpt && !ctrl_wr) |=> addr_valid);

    p_defer_load_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !blk_end) |=> $stable(act_start));

    p_status_set_r8: assert property (@(posedge clk) disable iff (rst)
        blk_end |=> status);

    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status && !stat_clr) |=> status);
endmodule

bind dma2d_addr_seq dma2d_addr_seq_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr_out(addr_out),
    .busy(busy), .blk_end(blk_end), .rpt(rpt), .status(status),
    .act_start(act_start)
);

// File: tb/test_dma2d_addr_seq.sv
module test_dma2d_addr_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic          addr_ready = 1'b1;
    logic          addr_valid;
    logic [AW-1:0] addr_out;
    logic          irq;

    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    acc_cnt = 0;
    int    rdy_mode = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #4 clk = ~clk;

    dma2d_addr_seq #(.AW(AW)) i_dma2d_addr_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_ready(addr_ready), .addr_valid(addr_valid), .addr_out(addr_out),
        .irq(irq)
    );

    // behavioural reference
    bit          m_en, m_irqen, m_rep, m_pend, m_status, m_busy;
    logic [31:0] m_cur, s_start, a_start;
    int          m_e, m_f;
    int          s_mode, s_esz, s_ecnt, s_fcnt, s_eidx, s_fidx;
    int          a_mode, a_esz, a_ecnt, a_fcnt, a_eidx, a_fidx;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst && addr_valid && addr_ready) acc_cnt++;
        if (rst) begin
            m_en = 0; m_irqen = 0; m_rep = 0; m_pend = 0; m_status = 0; m_busy = 0;
            m_cur = 0; s_start = 0; a_start = 0; m_e = 0; m_f = 0;
            s_mode = 0; s_esz = 0; s_ecnt = 0; s_fcnt = 0; s_eidx = 0; s_fidx = 0;
            a_mode = 0; a_esz = 0; a_ecnt = 0; a_fcnt = 0; a_eidx = 0; a_fidx = 0;
        end else begin
            bit acc, le, lf, bend, load;
            bit n_busy, n_en, n_pend, n_status;
            logic [31:0] rs, n_cur;
            int n_e, n_f, bytes, ec, fc;
            ec   = (a_ecnt == 0) ? 1 : a_ecnt;
            fc   = (a_fcnt == 0) ? 1 : a_fcnt;
            acc  = m_busy && m_en && addr_ready;
            le   = (m_e + 1) >= ec;
            lf   = (m_f + 1) >= fc;
            bend = acc && le && lf;
            load = m_pend && (!m_busy || bend);
            rs   = load ? s_start : a_start;
            bytes = 1 << a_esz;
            n_busy = m_busy; n_cur = m_cur; n_e = m_e; n_f = m_f;
            if (m_busy && !m_en) n_busy = 0;
            else if (!m_busy) begin
                if (m_en) begin n_busy = 1; n_cur = rs; n_e = 0; n_f = 0; end
            end else if (addr_ready) begin
                if (!le) begin
                    n_cur = m_cur + 32'(a_mode == 3 ? bytes + a_eidx - 1 : bytes);
                    n_e = m_e + 1;
                end else if (!lf) begin
                    n_cur = m_cur + 32'(a_mode == 3 ? bytes + a_fidx - 1 : bytes);
                    n_e = 0; n_f = m_f + 1;
                end else if (m_rep) begin
                    n_cur = rs; n_e = 0; n_f = 0;
                end else n_busy = 0;
            end
            n_en = m_en; n_pend = m_pend; n_status = m_status;
            if (load) begin
                a_mode = s_mode; a_esz = s_esz; a_start = s_start; a_ecnt = s_ecnt;
                a_fcnt = s_fcnt; a_eidx = s_eidx; a_fidx = s_fidx; n_pend = 0;
            end
            if (bend) begin
                n_status = 1;
                if (!m_rep) n_en = 0;
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: begin
                        n_en = wr_data[0]; m_irqen = wr_data[1]; m_rep = wr_data[2];
                        if (wr_data[3]) n_pend = 1;
                    end
                    3'd1: begin s_mode = int'(wr_data[1:0]); s_esz = int'(wr_data[3:2]); end
                    3'd2: s_start = wr_data;
                    3'd3: s_ecnt = int'(wr_data[15:0]);
                    3'd4: s_fcnt = int'(wr_data[15:0]);
                    3'd5: s_eidx = int'($signed(wr_data[15:0]));
                    3'd6: s_fidx = int'($signed(wr_data[15:0]));
                    default: if (wr_data[0] && !bend) n_status = 0;
                endcase
            end
            m_busy = n_busy; m_cur = n_cur; m_e = n_e; m_f = n_f;
            m_en = n_en; m_pend = n_pend; m_status = n_status;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit mv;
            mv = m_busy && m_en;
            chk(addr_valid == mv, {cur_req, " valid"}, addr_valid, mv);
            if (mv) chk(addr_out == m_cur, {cur_req, " addr"}, addr_out, m_cur);
            chk(irq == (m_status && m_irqen), {cur_req, " irq"}, irq, m_status && m_irqen);
        end
        case (rdy_mode)
            1:       addr_ready <= (cyc % 3) != 1;
            2:       addr_ready <= (cyc % 5) < 2;
            default: addr_ready <= 1'b1;
        endcase
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: quiet after reset
        cur_req = "R1";
        idle(3);
        chk(addr_valid == 1'b0, "R1 valid after reset", addr_valid, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R2: post-increment, 2-byte elements, single block
        cur_req = "R2";
        wr(3'd1, 32'h4);
        wr(3'd2, 32'h1000);
        wr(3'd3, 32'd4);
        wr(3'd4, 32'd2);
        acc_cnt = 0;
        wr(3'd0, 32'h9);
        idle(30);
        chk(acc_cnt == 8, "R5 block length 4x2", acc_cnt, 8);
        chk(addr_valid == 1'b0, "R6 single block stops", addr_valid, 0);

        // R3 R4 R10: double index, 4-byte, stalls
        cur_req = "R3_R4_R10";
        rdy_mode = 1;
        wr(3'd1, 32'hB);
        wr(3'd2, 32'h2000);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd5);
        wr(3'd6, 32'h0000FFEC);
        acc_cnt = 0;
        wr(3'd0, 32'h9);
        idle(50);
        chk(acc_cnt == 9, "R3 R4 double-index block length", acc_cnt, 9);
        rdy_mode = 0;

        // R5: element count zero acts as one
        cur_req = "R5";
        wr(3'd1, 32'h0);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd2);
        acc_cnt = 0;
        wr(3'd0, 32'h9);
        idle(15);
        chk(acc_cnt == 2, "R5 zero count as one", acc_cnt, 2);

        // R8: status is set from earlier blocks; W1C behaviour
        cur_req = "R8";
        wr(3'd0, 32'h2);
        idle(1);
        chk(irq == 1'b1, "R8 irq with status set", irq, 1);
        wr(3'd7, 32'h0);
        idle(1);
        chk(irq == 1'b1, "R8 write 0 keeps status", irq, 1);
        wr(3'd7, 32'h1);
        idle(1);
        chk(irq == 1'b0, "R8 write 1 clears status", irq, 0);

        // R6 R7: repeating block with mid-block reload
        cur_req = "R6_R7";
        rdy_mode = 2;
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h3000);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd2);
        wr(3'd0, 32'hF);
        idle(7);
        wr(3'd2, 32'h4000);
        wr(3'd1, 32'h3);
        idle(3);
        wr(3'd0, 32'hF);
        idle(30);
        chk(irq == 1'b1, "R8 status held through repeats", irq, 1);

        // R9: disable mid-block, then restart from top
        cur_req = "R9";
        rdy_mode = 0;
        wr(3'd0, 32'h6);
        idle(1);
        chk(addr_valid == 1'b0, "R9 disable stops issue", addr_valid, 0);
        idle(4);
        wr(3'd0, 32'h7);
        idle(1);
        chk(addr_valid == 1'b1 && addr_out == 32'h4000, "R9 restart at start", addr_out, 32'h4000);
        idle(12);
        wr(3'd0, 32'h0);
        idle(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule